// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block turns a one-bit serial stream into parallel words, eight bits wide by default. Everything runs on the serial bit clock. An internal phase counter splits that clock into word periods. A registered divided clock is brought out as `pclk_o`. At the end of each period a parallel register takes the most recent word, and a one-cycle strobe marks the load so that logic on the same clock can use the word directly.

Framing is left to the host. When the host decides the word boundary is wrong, it raises `sync_in`. The block first qualifies the request on two consecutive samples. It then holds the phase counter for a single bit time. That one word period becomes one bit longer, the oldest bit of the period drops out of the framing, and every later word boundary moves one bit later in the stream. Each qualified pulse slips exactly once.

Top module: `ser2par`

## Requirements
- R1: While `rst` is sampled high, `pdata_o`, `pclk_o` and `word_stb_o` are all zero after the next rising edge, whatever state the block held before.
- R2: Each word is ordered most-significant first: the earliest of its eight bits appears on `pdata_o[7]` and the latest on `pdata_o[0]`.
- R3: Counting the first rising edge after reset release as edge 0, the first word loads on edge 7 and holds bits 0..7. Without a slip, a word then loads every eight edges.
- R4: Outside a slip, `pclk_o` stays low for four serial cycles and then high for four. It falls on exactly the edge where a word loads, and `word_stb_o` is never high while `pclk_o` is high.
- R5: When `sync_in` is sampled high on two consecutive edges a and a+1, the phase counter holds at edge a+2. That word period lasts nine cycles, and each later word is taken one bit later in the stream.
- R6: A `sync_in` pulse sampled high on only one edge causes no slip, so the strobe, `pclk_o` and data timing are unchanged.
- R7: However long `sync_in` stays high, it causes one slip only. Another slip needs `sync_in` to be sampled low and then high again on two consecutive edges.
- R8: If the held edge would have been a load edge, the load and its strobe move to the following edge, and the word then holds the eight bits ending at that edge.
- R9: The realignment takes effect within two parallel-clock periods of the rising edge of `sync_in`.
- R10: `word_stb_o` is high for exactly one cycle per load. `pdata_o` changes only on an edge that raises the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Serial data, one bit per rising edge |
| sync_in | input | 1 | Slip request; must be high for two consecutive samples |
| pclk_o | output | 1 | Registered divided clock, low half then high half of each word period |
| pdata_o | output | W | Parallel word, most-significant bit received first |
| word_stb_o | output | 1 | One-cycle pulse on the cycle a new word appears |

## Verification
The difficult case is a qualified slip whose held edge falls on the cycle that would otherwise load a word, so that the hold and the load compete for the same edge. The bench sweeps the start of the sync pulse across all eight counter phases, which makes the held edge land once on the load phase, and repeats the sweep for pulse lengths of one, two, three and five samples. The bench rebuilds the expected strobe, divided clock and word for every edge from its own record of the bits it sent and the edges it expects to be held. When the hold lands on the load phase, the load must come one edge later and carry the eight bits that end at that later edge.

// File: rtl/ser2par.sv
module ser2par #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdin,
  input  logic         sync_in,
  output logic         pclk_o,
  output logic [W-1:0] pdata_o,
  output logic         word_stb_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-2:0]  sr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          s1, s2, seen;
  logic          hold, load;

  assign hold   = s1 & s2 & ~seen;
  assign load   = (cnt == LAST) & ~hold;
  assign cnt_nx = hold ? cnt : ((cnt == LAST) ? '0 : cnt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      cnt        <= '0;
      s1         <= 1'b0;
      s2         <= 1'b0;
      seen       <= 1'b0;
      pclk_o     <= 1'b0;
      pdata_o    <= '0;
      word_stb_o <= 1'b0;
    end else begin
      sr         <= {sr[W-3:0], sdin};
      cnt        <= cnt_nx;
      s1         <= sync_in;
      s2         <= s1;
      seen       <= s1 & s2;
      pclk_o     <= cnt_nx[CW-1];
      word_stb_o <= load;
      if (load) pdata_o <= {sr, sdin};
    end
  end

  p_stb_single_r10: assert property (@(posedge clk) disable iff (rst)
    word_stb_o |=> !word_stb_o);

  p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !word_stb_o) |-> $stable(pdata_o));

  p_fall_on_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pclk_o)) |-> word_stb_o);

  p_stb_low_half_r4: assert property (@(posedge clk) disable iff (rst)
    word_stb_o |-> !pclk_o);

  p_one_slip_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> !hold);

  p_qualified_r5: assert property (@(posedge clk) disable iff (rst)
    hold |-> ($past(sync_in) && $past(sync_in, 2)));
endmodule

// File: tb/sim_ser2par.sv
module sim_ser2par;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sdin = 1'b0;
  logic       sync_in = 1'b0;
  logic       pclk_o;
  logic [7:0] pdata_o;
  logic       word_stb_o;

  int vectors = 0;
  int errors  = 0;
  int n, hb, sync_a, sync_len, last_hold;
  logic bits  [0:255];
  logic holdf [0:255];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  ser2par #(.W(8)) u0 (
    .clk(clk), .rst(rst), .sdin(sdin), .sync_in(sync_in),
    .pclk_o(pclk_o), .pdata_o(pdata_o), .word_stb_o(word_stb_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: got %h expected %h", req, n, act, exp);
    end
  endtask

  function automatic string tag_for(input int edge_i);
    if (sync_len == 1 && edge_i >= sync_a) return "R6";
    if (sync_len >= 5 && edge_i >= sync_a + 3) return "R7";
    if (sync_len >= 2 && edge_i >= sync_a && edge_i <= sync_a + 16) return "R9";
    if (sync_len >= 2 && edge_i > sync_a) return "R5";
    return "R10";
  endfunction

  task automatic check_edge;
    int cb, ca;
    logic exp_load, deferred;
    logic [7:0] w;
    string t;
    cb = (n - hb) % 8;
    ca = (n + 1 - hb - int'(holdf[n])) % 8;
    exp_load = !holdf[n] && cb == 7;
    deferred = (n > 0) && holdf[n-1] && ((n - 1 - (hb - int'(holdf[n-1]))) % 8 == 7);
    t = tag_for(n);
    chk((n == 7) ? "R3" : t, {7'd0, word_stb_o}, {7'd0, exp_load});
    chk("R4", {7'd0, pclk_o}, {7'd0, logic'(ca >= 4)});
    if (exp_load) begin
      w = '0;
      for (int k = 0; k < 8; k++) w[k] = bits[n - k];
      if (deferred) chk("R8", pdata_o, w);
      else if (last_hold >= 0 && n - last_hold < 9) chk("R5", pdata_o, w);
      else chk("R2", pdata_o, w);
    end
    hb += int'(holdf[n]);
    if (holdf[n]) last_hold = n;
  endtask

  task automatic run_edge(input logic s);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sdin = lfsr[0];
    sync_in = s;
    @(posedge clk);
    bits[n] = sdin;
    @(negedge clk);
    check_edge();
    n++;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    sync_in = 1'b1;
    sdin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    n = -1;
    chk("R1", pdata_o, 8'h00);
    chk("R1", {6'd0, pclk_o, word_stb_o}, 8'h00);
    rst = 1'b0;
    sync_in = 1'b0;
    n = 0;
    hb = 0;
    last_hold = -100;
    for (int i = 0; i < 256; i++) holdf[i] = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int lens [4] = '{1, 2, 3, 5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {6'd0, pclk_o, word_stb_o}, 8'h00);
    for (int li = 0; li < 4; li++) begin
      for (int off = 0; off < 8; off++) begin
        do_reset();
        sync_len = lens[li];
        sync_a = 20 + off;
        if (sync_len >= 2) holdf[sync_a + 2] = 1'b1;
        if (sync_len >= 5) holdf[sync_a + 14] = 1'b1;
        for (int e = 0; e < 80; e++) begin
          logic s;
          s = (e >= sync_a && e < sync_a + sync_len) ||
              (sync_len >= 5 && e >= sync_a + 12 && e < sync_a + 14);
          run_edge(s);
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule